// File: doc/BRIEF.md
# Shared Fully Associative Tag Directory

This block keeps the tag and state bits of a small fully associative cache that two cores use at once. Every slot holds a tag, a valid bit, a dirty bit, a writer-core bit and a lock bit with the core that took the lock. Each core has its own search and slot-choice logic over the single slot array. A core issues one request per cycle: lookup, write, allocate or flush. The same cycle it gets back hit, miss and a slot index. The data array, the refill from memory and the writeback path sit outside. The block only raises a per-core writeback strobe, with the slot index on that core's slot output. The core answers later with a done pulse.

Two cores that miss on the same address can each allocate their own slot, so one tag can end up in more than one slot. The design accepts this. A dirty line is seen only by the core that wrote it. Hits prefer dirty copies. A background scrubber visits one slot per cycle and removes a duplicate, taking a clean copy before a dirty one.

Top module: `shared_tag_dir`

## Requirements
- R1: After reset, no slot is valid, dirty or locked. Lookups on both cores miss, and the first allocation gets slot 0.
- R2: A request's tag is compared with every slot at once. Request outputs are combinational in the request cycle, and state changes at the next rising clock edge. Op encoding: 00 lookup, 01 write, 10 allocate, 11 flush.
- R3: When several visible slots match, a dirty match is reported before any clean one. Within the chosen group, the lowest index wins.
- R4: A dirty slot whose writer is the other core is invisible: a lookup, write or flush on its tag misses.
- R5: A slot locked by the other core is invisible to lookups and is never chosen for allocation.
- R6: An allocation takes the lowest unlocked invalid slot. Failing that, it takes the lowest unlocked clean slot. Failing that, it takes the lowest unlocked dirty slot written by the requester and raises the writeback strobe. With no candidate it reports miss, and the caller must retry.
- R7: If both cores' state-changing requests aim at the same slot in one cycle, core 0 proceeds and core 1 reports miss with no effect. A retry by core 1 in the next cycle takes another slot.
- R8: An allocated slot is locked by its allocating core until that core pulses done. The done pulse releases every lock the core holds.
- R9: A flush that hits a dirty slot raises the writeback strobe with that slot index. The slot stays valid, becomes clean and stays locked until done. A flush on a clean hit reports hit and raises no strobe.
- R10: The scrubber invalidates an unlocked slot whose valid tag also sits in another valid slot. It removes a clean copy while any clean duplicate remains, never the dirty one. Duplicates are gone within two passes over the slots when no core touches them.
- R11: A write that hits marks the slot dirty, with the requesting core as writer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| c0_req_i | input | 1 | Core 0 request valid |
| c0_op_i | input | 2 | Core 0 operation |
| c0_tag_i | input | TAG_W | Core 0 request tag |
| c0_done_i | input | 1 | Core 0 refill/writeback done, releases its locks |
| c0_hit_o | output | 1 | Core 0 hit, or allocation granted |
| c0_miss_o | output | 1 | Core 0 miss, or allocation must retry |
| c0_slot_o | output | IDX_W | Core 0 selected slot |
| c0_wb_req_o | output | 1 | Core 0 writeback strobe for c0_slot_o |
| c1_req_i | input | 1 | Core 1 request valid |
| c1_op_i | input | 2 | Core 1 operation |
| c1_tag_i | input | TAG_W | Core 1 request tag |
| c1_done_i | input | 1 | Core 1 refill/writeback done, releases its locks |
| c1_hit_o | output | 1 | Core 1 hit, or allocation granted |
| c1_miss_o | output | 1 | Core 1 miss, or allocation must retry |
| c1_slot_o | output | IDX_W | Core 1 selected slot |
| c1_wb_req_o | output | 1 | Core 1 writeback strobe for c1_slot_o |

## Verification
Two pairs of functions can land in the same cycle. The first pair is two allocations that pick the same free slot. The bench issues them together from reset and expects core 1 to be refused, then expects its retry in the next cycle to take the following slot. The second pair is a duplicate pair becoming visible while the scrubber can remove it. Two copies are made, one clean and one dirty. Core 0 looks up the tag in the one cycle in which the second lock has just been released but the scrub edge has not yet passed, and must get the dirty copy. After the scrub interval, core 1 must miss, and a new allocation must land in the freed clean slot.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;

  typedef enum logic [1:0] {
    OP_LOOK  = 2'b00,
    OP_WRITE = 2'b01,
    OP_ALLOC = 2'b10,
    OP_FLUSH = 2'b11
  } dir_op_e;

  localparam int NUM_CORES = 2;

endpackage

// File: rtl/tagdir_prio.sv
module tagdir_prio #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);

  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/tagdir_core_sel.sv
module tagdir_core_sel #(
  parameter int N     = 8,
  parameter int TAG_W = 16,
  parameter int IDX_W = 3,
  parameter int CORE  = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N-1:0]          v_i,
  input  logic [N-1:0]          d_i,
  input  logic [N-1:0]          own_i,
  input  logic [N-1:0]          lk_i,
  input  logic [N-1:0]          lko_i,
  input  logic [N-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]      tag_i,
  output logic                  hit_any_o,
  output logic [IDX_W-1:0]      hit_idx_o,
  output logic                  hit_dirty_o,
  output logic                  vic_any_o,
  output logic [IDX_W-1:0]      vic_idx_o,
  output logic                  vic_dirty_o
);

  localparam logic ME = (CORE != 0);

  function automatic logic [N-1:0] tiered(input logic [N-1:0] a,
                                          input logic [N-1:0] b,
                                          input logic [N-1:0] c);
    if (|a)      return a;
    else if (|b) return b;
    else         return c;
  endfunction

  logic [N-1:0] foreign_lock, foreign_dirty, visible, match_vec;
  logic [N-1:0] dmatch, cmatch, hit_cand;
  logic [N-1:0] free_vec, clean_vec, mine_dirty, vic_cand;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      foreign_lock[i]  = lk_i[i] && (lko_i[i] != ME);
      foreign_dirty[i] = d_i[i] && (own_i[i] != ME);
      visible[i]       = v_i[i] && !foreign_lock[i] && !foreign_dirty[i];
      match_vec[i]     = visible[i] && (tags_i[i] == tag_i);
      free_vec[i]      = !v_i[i] && !lk_i[i];
      clean_vec[i]     = v_i[i] && !d_i[i] && !lk_i[i];
      mine_dirty[i]    = v_i[i] && d_i[i] && !lk_i[i] && (own_i[i] == ME);
    end
  end

  assign dmatch   = match_vec & d_i;
  assign cmatch   = match_vec & ~d_i;
  assign hit_cand = tiered(dmatch, cmatch, '0);
  assign vic_cand = tiered(free_vec, clean_vec, mine_dirty);

  tagdir_prio #(.N(N), .IDX_W(IDX_W)) u_hit_prio (
    .req_i(hit_cand), .any_o(hit_any_o), .idx_o(hit_idx_o)
  );

  tagdir_prio #(.N(N), .IDX_W(IDX_W)) u_vic_prio (
    .req_i(vic_cand), .any_o(vic_any_o), .idx_o(vic_idx_o)
  );

  assign hit_dirty_o = d_i[hit_idx_o];
  assign vic_dirty_o = ~(|free_vec) & ~(|clean_vec);

  // R3: a clean hit is only reported when no visible dirty copy matches
  assert_dirty_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_any_o && !d_i[hit_idx_o]) |-> (dmatch == '0));

  // R4/R5: the chosen hit is never hidden from this core
  assert_hit_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any_o |-> !((d_i[hit_idx_o] && own_i[hit_idx_o] != ME) ||
                    (lk_i[hit_idx_o] && lko_i[hit_idx_o] != ME)));

endmodule

// File: rtl/tagdir_scrub.sv
module tagdir_scrub #(
  parameter int N     = 8,
  parameter int TAG_W = 16,
  parameter int IDX_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N-1:0]            v_i,
  input  logic [N-1:0]            d_i,
  input  logic [N-1:0]            lk_i,
  input  logic [N-1:0][TAG_W-1:0] tags_i,
  input  logic [N-1:0]            touched_i,
  output logic                    kill_o,
  output logic [IDX_W-1:0]        kill_idx_o
);

  logic [IDX_W-1:0] ptr_q;
  logic [N-1:0]     twin;
  logic             blocked, has_twin, has_clean_twin, cand;

  always_comb begin
    for (int j = 0; j < N; j++)
      twin[j] = v_i[j] && (tags_i[j] == tags_i[ptr_q]) && (IDX_W'(j) != ptr_q);
  end

  assign has_twin       = |twin;
  assign has_clean_twin = |(twin & ~d_i);
  assign blocked        = touched_i[ptr_q];
  assign cand           = v_i[ptr_q] && !lk_i[ptr_q] && has_twin &&
                          (!d_i[ptr_q] || !has_clean_twin);
  assign kill_o         = cand && !blocked;
  assign kill_idx_o     = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else if (!blocked) ptr_q <= (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
  end

  // R10: a dirty slot is never removed while a clean twin survives
  assert_clean_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_o && d_i[kill_idx_o]) |-> !has_clean_twin);

endmodule

// File: rtl/shared_tag_dir.sv
module shared_tag_dir #(
  parameter int NUM_SLOTS = 8,
  parameter int TAG_W     = 16,
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             c0_req_i,
  input  logic [1:0]       c0_op_i,
  input  logic [TAG_W-1:0] c0_tag_i,
  input  logic             c0_done_i,
  output logic             c0_hit_o,
  output logic             c0_miss_o,
  output logic [IDX_W-1:0] c0_slot_o,
  output logic             c0_wb_req_o,
  input  logic             c1_req_i,
  input  logic [1:0]       c1_op_i,
  input  logic [TAG_W-1:0] c1_tag_i,
  input  logic             c1_done_i,
  output logic             c1_hit_o,
  output logic             c1_miss_o,
  output logic [IDX_W-1:0] c1_slot_o,
  output logic             c1_wb_req_o
);
  import tagdir_pkg::*;

  localparam int N = NUM_SLOTS;
  localparam int C = NUM_CORES;

  logic [N-1:0]            v_q, d_q, own_q, lk_q, lko_q;
  logic [N-1:0][TAG_W-1:0] tag_q;

  logic [C-1:0]            req, done;
  dir_op_e                 op   [C];
  logic [C-1:0][TAG_W-1:0] rtag;

  logic [C-1:0]            hit_any, hit_dirty, vic_any, vic_dirty;
  logic [C-1:0][IDX_W-1:0] hit_idx, vic_idx;

  logic [C-1:0]            mod_raw, mod_eff, gnt_raw, gnt, wb_raw, wb, alloc_gnt;
  logic [C-1:0][IDX_W-1:0] tgt, slot;
  logic                    core1_drop;
  logic [N-1:0]            touched;
  logic                    scrub_kill;
  logic [IDX_W-1:0]        scrub_idx;

  assign req     = {c1_req_i, c0_req_i};
  assign done    = {c1_done_i, c0_done_i};
  assign op[0]   = dir_op_e'(c0_op_i);
  assign op[1]   = dir_op_e'(c1_op_i);
  assign rtag[0] = c0_tag_i;
  assign rtag[1] = c1_tag_i;

  for (genvar c = 0; c < C; c++) begin : g_core
    tagdir_core_sel #(.N(N), .TAG_W(TAG_W), .IDX_W(IDX_W), .CORE(c)) u_sel (
      .clk(clk), .rst_n(rst_n),
      .v_i(v_q), .d_i(d_q), .own_i(own_q), .lk_i(lk_q), .lko_i(lko_q),
      .tags_i(tag_q), .tag_i(rtag[c]),
      .hit_any_o(hit_any[c]), .hit_idx_o(hit_idx[c]), .hit_dirty_o(hit_dirty[c]),
      .vic_any_o(vic_any[c]), .vic_idx_o(vic_idx[c]), .vic_dirty_o(vic_dirty[c])
    );
  end

  // per-core decision before arbitration
  always_comb begin
    for (int c = 0; c < C; c++) begin
      mod_raw[c] = 1'b0;
      wb_raw[c]  = 1'b0;
      gnt_raw[c] = 1'b0;
      tgt[c]     = hit_idx[c];
      slot[c]    = hit_idx[c];
      if (req[c]) begin
        unique case (op[c])
          OP_LOOK:  gnt_raw[c] = hit_any[c];
          OP_WRITE: begin
            gnt_raw[c] = hit_any[c];
            mod_raw[c] = hit_any[c];
          end
          OP_FLUSH: begin
            gnt_raw[c] = hit_any[c];
            mod_raw[c] = hit_any[c] && hit_dirty[c];
            wb_raw[c]  = hit_any[c] && hit_dirty[c];
          end
          OP_ALLOC: begin
            gnt_raw[c] = vic_any[c];
            mod_raw[c] = vic_any[c];
            wb_raw[c]  = vic_any[c] && vic_dirty[c];
            tgt[c]     = vic_idx[c];
            slot[c]    = vic_idx[c];
          end
          default: gnt_raw[c] = 1'b0;
        endcase
      end
    end
  end

  // core 0 wins a same-slot collision
  assign core1_drop = mod_raw[0] && mod_raw[1] && (tgt[0] == tgt[1]);
  assign mod_eff    = {mod_raw[1] && !core1_drop, mod_raw[0]};
  assign gnt        = {gnt_raw[1] && !core1_drop, gnt_raw[0]};
  assign wb         = {wb_raw[1] && !core1_drop, wb_raw[0]};

  always_comb begin
    for (int c = 0; c < C; c++)
      alloc_gnt[c] = gnt[c] && (op[c] == OP_ALLOC);
    touched = '0;
    for (int c = 0; c < C; c++)
      if (mod_eff[c]) touched[tgt[c]] = 1'b1;
  end

  tagdir_scrub #(.N(N), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_scrub (
    .clk(clk), .rst_n(rst_n),
    .v_i(v_q), .d_i(d_q), .lk_i(lk_q), .tags_i(tag_q),
    .touched_i(touched), .kill_o(scrub_kill), .kill_idx_o(scrub_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q   <= '0;
      d_q   <= '0;
      own_q <= '0;
      lk_q  <= '0;
      lko_q <= '0;
      tag_q <= '0;
    end else begin
      for (int i = 0; i < N; i++)
        if ((done[0] && !lko_q[i]) || (done[1] && lko_q[i])) lk_q[i] <= 1'b0;
      if (scrub_kill) begin
        v_q[scrub_idx] <= 1'b0;
        d_q[scrub_idx] <= 1'b0;
      end
      for (int c = 0; c < C; c++) begin
        if (mod_eff[c]) begin
          unique case (op[c])
            OP_WRITE: begin
              d_q[tgt[c]]   <= 1'b1;
              own_q[tgt[c]] <= (c != 0);
            end
            OP_FLUSH: begin
              d_q[tgt[c]]   <= 1'b0;
              lk_q[tgt[c]]  <= 1'b1;
              lko_q[tgt[c]] <= (c != 0);
            end
            OP_ALLOC: begin
              v_q[tgt[c]]   <= 1'b1;
              d_q[tgt[c]]   <= 1'b0;
              tag_q[tgt[c]] <= rtag[c];
              own_q[tgt[c]] <= (c != 0);
              lk_q[tgt[c]]  <= 1'b1;
              lko_q[tgt[c]] <= (c != 0);
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign c0_hit_o    = gnt[0];
  assign c0_miss_o   = req[0] && !gnt[0];
  assign c0_slot_o   = slot[0];
  assign c0_wb_req_o = wb[0];
  assign c1_hit_o    = gnt[1];
  assign c1_miss_o   = req[1] && !gnt[1];
  assign c1_slot_o   = slot[1];
  assign c1_wb_req_o = wb[1];

  // R7: simultaneous grants never share a slot
  assert_alloc_distinct_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_gnt[0] && alloc_gnt[1]) |-> (c0_slot_o != c1_slot_o));

  // R8: a granted allocation leaves the slot valid and locked by core 0
  assert_alloc_locks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_gnt[0] && !scrub_kill) |=> (v_q[$past(c0_slot_o)] && lk_q[$past(c0_slot_o)] &&
                     !lko_q[$past(c0_slot_o)]));

  // R9: a flush writeback keeps the slot valid and makes it clean
  assert_flush_keeps_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (c0_wb_req_o && op[0] == OP_FLUSH) |=> (v_q[$past(c0_slot_o)] && !d_q[$past(c0_slot_o)]));

  // R10: a scrubbed slot is invalid afterwards
  assert_scrub_kill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_kill |=> !v_q[$past(scrub_idx)]);

  // R4: core 1 never hits a line that core 0 holds dirty
  assert_dirty_hidden_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (c1_hit_o && op[1] != OP_ALLOC) |-> !(d_q[c1_slot_o] && !own_q[c1_slot_o]));

endmodule

// File: tb/shared_tag_dir_test.sv
module shared_tag_dir_test;

  localparam int NS   = 4;
  localparam int TW   = 8;
  localparam int IW   = 2;
  localparam logic [1:0] LOOK = 2'b00, WRITE = 2'b01, ALLOC = 2'b10, FLUSH = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic c0_req = 0, c1_req = 0, c0_done = 0, c1_done = 0;
  logic [1:0] c0_op = 0, c1_op = 0;
  logic [TW-1:0] c0_tag = 0, c1_tag = 0;
  logic c0_hit, c0_miss, c0_wb, c1_hit, c1_miss, c1_wb;
  logic [IW-1:0] c0_slot, c1_slot;
  int n_checks = 0, n_fail = 0;

  always #4 clk = ~clk;

  shared_tag_dir #(.NUM_SLOTS(NS), .TAG_W(TW)) uut (
    .clk(clk), .rst_n(rst_n),
    .c0_req_i(c0_req), .c0_op_i(c0_op), .c0_tag_i(c0_tag), .c0_done_i(c0_done),
    .c0_hit_o(c0_hit), .c0_miss_o(c0_miss), .c0_slot_o(c0_slot), .c0_wb_req_o(c0_wb),
    .c1_req_i(c1_req), .c1_op_i(c1_op), .c1_tag_i(c1_tag), .c1_done_i(c1_done),
    .c1_hit_o(c1_hit), .c1_miss_o(c1_miss), .c1_slot_o(c1_slot), .c1_wb_req_o(c1_wb)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask
  task automatic rest();
    c0_req = 0; c1_req = 0; c0_done = 0; c1_done = 0;
  endtask
  task automatic go0(input logic [1:0] op, input logic [TW-1:0] tag);
    c0_req = 1; c0_op = op; c0_tag = tag;
  endtask
  task automatic go1(input logic [1:0] op, input logic [TW-1:0] tag);
    c1_req = 1; c1_op = op; c1_tag = tag;
  endtask
  task automatic done0(); rest(); c0_done = 1; tick(); c0_done = 0; endtask
  task automatic done1(); rest(); c1_done = 1; tick(); c1_done = 0; endtask
  task automatic do_reset();
    rest(); rst_n = 0; repeat (3) tick(); rst_n = 1; tick();
  endtask

  task automatic test_reset();
    do_reset();
    go0(LOOK, 8'h00); go1(LOOK, 8'h00); #1;
    check("R1 c0 miss after reset", c0_miss, 1);
    check("R1 c1 miss after reset", c1_miss, 1);
    tick(); rest();
    go0(ALLOC, 8'h11); #1;
    check("R1 first alloc granted", c0_hit, 1);
    check("R1 first alloc slot", c0_slot, 0);
    check("R6 no writeback on free slot", c0_wb, 0);
    tick(); rest();
    go0(LOOK, 8'h11); #1;
    check("R2 lookup of allocated tag", c0_hit, 1);
    tick(); done0();
  endtask

  task automatic test_collision();
    do_reset();
    go0(ALLOC, 8'h21); go1(ALLOC, 8'h22); #1;
    check("R7 core0 wins", c0_hit, 1);
    check("R7 core0 slot", c0_slot, 0);
    check("R7 core1 refused", c1_miss, 1);
    tick(); rest();
    go1(ALLOC, 8'h22); #1;
    check("R7 core1 retry granted", c1_hit, 1);
    check("R5 retry skips locked slot", c1_slot, 1);
    tick(); rest();
    go0(LOOK, 8'h22); #1;
    check("R5 locked by other invisible", c0_miss, 1);
    tick(); done1();
    go0(LOOK, 8'h22); go1(LOOK, 8'h21); #1;
    check("R8 visible after done", c0_hit, 1);
    check("R8 visible slot", c0_slot, 1);
    check("R8 other lock still held", c1_miss, 1);
    tick(); done0();
    go1(LOOK, 8'h21); #1;
    check("R8 released by done", c1_hit, 1);
    tick(); rest();
  endtask

  task automatic test_dups();
    do_reset();
    go1(ALLOC, 8'h40); #1;
    check("R6 core1 alloc slot", c1_slot, 0);
    tick(); rest();
    go0(ALLOC, 8'h40); #1;
    check("R5 core0 skips slot locked by core1", c0_slot, 1);
    tick(); done0();
    go0(WRITE, 8'h40); #1;
    check("R11 write hits own copy", c0_hit, 1);
    check("R11 write slot", c0_slot, 1);
    tick(); done1();
    go0(LOOK, 8'h40); #1;
    check("R3 dirty copy preferred", c0_slot, 1);
    check("R3 hit", c0_hit, 1);
    tick(); rest();
    repeat (2 * NS + 2) tick();
    go1(LOOK, 8'h40); #1;
    check("R10/R4 clean copy removed, dirty hidden", c1_miss, 1);
    tick(); rest();
    go0(LOOK, 8'h40); #1;
    check("R10 dirty copy kept", c0_hit, 1);
    check("R10 dirty copy slot", c0_slot, 1);
    tick(); rest();
    go1(ALLOC, 8'h55); #1;
    check("R10 freed slot reused", c1_slot, 0);
    check("R10 reuse without writeback", c1_wb, 0);
    tick(); done1();
  endtask

  task automatic test_flush();
    do_reset();
    go0(ALLOC, 8'h60); tick(); done0();
    go0(FLUSH, 8'h60); #1;
    check("R9 flush clean hit", c0_hit, 1);
    check("R9 flush clean no strobe", c0_wb, 0);
    tick(); rest();
    go0(WRITE, 8'h60); tick(); rest();
    go1(LOOK, 8'h60); #1;
    check("R4 dirty of core0 hidden from core1", c1_miss, 1);
    tick(); rest();
    go0(FLUSH, 8'h60); #1;
    check("R9 flush dirty strobe", c0_wb, 1);
    check("R9 flush slot", c0_slot, 0);
    tick(); rest();
    go0(LOOK, 8'h60); go1(LOOK, 8'h60); #1;
    check("R9 slot stays valid", c0_hit, 1);
    check("R9 locked during writeback", c1_miss, 1);
    tick(); done0();
    go1(LOOK, 8'h60); #1;
    check("R9 clean after done", c1_hit, 1);
    tick(); rest();
  endtask

  task automatic test_evict();
    do_reset();
    for (int i = 0; i < NS; i++) begin
      go0(ALLOC, 8'h70 + 8'(i)); #1;
      check("R6 fill order", c0_slot, i);
      tick(); done0();
      go0(WRITE, 8'h70 + 8'(i)); tick(); rest();
    end
    go1(ALLOC, 8'h80); #1;
    check("R6 no candidate for core1", c1_miss, 1);
    tick(); rest();
    go0(ALLOC, 8'h90); #1;
    check("R6 own dirty victim", c0_hit, 1);
    check("R6 victim slot", c0_slot, 0);
    check("R6 writeback strobe", c0_wb, 1);
    tick(); rest();
    go0(LOOK, 8'h70); #1;
    check("R6 evicted tag gone", c0_miss, 1);
    tick(); done0();
    go1(ALLOC, 8'h91); #1;
    check("R6 clean victim slot", c1_slot, 0);
    check("R6 clean victim no strobe", c1_wb, 0);
    tick(); done1();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    test_reset();
    test_collision();
    test_dups();
    test_flush();
    test_evict();
    summary();
    $finish;
  end

endmodule